// File: doc/BRIEF.md
# Converter Serial Status and Result Port

This block is the device-side digital port of a conversion engine, reached over three wires: an active-low chip select, a host-driven serial clock and a serial data line. It tracks three states: converting, sleeping with a finished result, and shifting that result out. While the chip select is low, the data line carries a busy flag: 1 while a conversion runs and 0 once a result is waiting. That lets the line act as a completion interrupt. A host that finds the flag low clocks out a 19-bit word. The new conversion starts right after the last bit, or at once if the host drops the read early by raising the chip select.

The conversion is modelled by a counter that runs for a set number of system-clock cycles. When the counter finishes, the block captures a sign bit and a magnitude from an input port. Both host-side inputs are brought into the fast system clock through multi-flop synchronizers, and their edges are detected there. The tri-state data pin is represented by a data value and an output-enable.

Top module: `conv_serial_port`

## Requirements
- R1: While the synchronized chip select is high, `sdo_oe_o` is 0 and `sdo_o` is 0.
- R2: During a conversion, with chip select low, `sdo_oe_o` is 1 and `sdo_o` is 1.
- R3: A conversion lasts `CONV_CYCLES` system cycles. At its end `result_i` is captured and the block sleeps. With chip select low, `sdo_o` is then 0.
- R4: The captured result is held through any length of sleep, whatever the chip select level. Later changes on `result_i` do not alter the word that is read.
- R5: The read word is 19 bits, sent most significant first, and each bit is changed only on a serial clock falling edge. Bit 18 is the busy flag (0), bit 17 is a constant 0, bit 16 is `result_i[16]` (sign) and bits 15..0 are `result_i[15:0]`.
- R6: The 19th falling edge of the serial clock during a read starts a new conversion, and `sdo_o` returns to 1.
- R7: Chip select rising after the first serial clock rising edge, and before the 19th falling edge, abandons the read and starts a new conversion at once.
- R8: Chip select rising while sleeping, before any serial clock rising edge, keeps the block asleep with its word intact.
- R9: Serial clock edges during a conversion are ignored and do not advance the bit position.
- R10: `sdo_oe_o` follows a change on `csn_i` on the second system clock rising edge after the change.
- R11: Serial clock edges while chip select is high are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than the serial clock |
| rst_n | input | 1 | Asynchronous active-low reset; a conversion begins after it |
| csn_i | input | 1 | Chip select from the host, active low, asynchronous |
| sclk_i | input | 1 | Serial clock from the host, asynchronous |
| result_i | input | MAG_W+1 | Next result: sign in the top bit, magnitude below it |
| sdo_o | output | 1 | Serial data value (busy flag or result bit) |
| sdo_oe_o | output | 1 | Output-enable for the data pin |

## Verification
The assertions assume each serial clock level and each chip select level lasts at least three system cycles, so the synchronizers never merge two edges. They also assume the serial clock rests low when chip select falls. The bench holds every serial clock half period and every chip select level for six system cycles or more. It starts each read only after the busy flag has been seen low. A behavioural model, fed the same raw inputs, is compared with both outputs on every system clock.

// File: rtl/cssp_pkg.sv
`timescale 1ns/1ps
package cssp_pkg;
   typedef enum logic [1:0] {
      ST_CONV  = 2'd0,
      ST_SLEEP = 2'd1,
      ST_DATA  = 2'd2
   } cssp_state_e;
endpackage

// File: rtl/cssp_sync.sv
`timescale 1ns/1ps
// Multi-flop synchronizer with one extra flop holding the previous level.
module cssp_sync #(
   parameter int   STAGES  = 2,
   parameter logic RST_VAL = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_i,
   output logic lvl_o,
   output logic prev_o
);
   localparam int PIPE_W = STAGES + 1;

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("cssp_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [PIPE_W-1:0] pipe_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pipe_q <= {PIPE_W{RST_VAL}};
      else        pipe_q <= {pipe_q[PIPE_W-2:0], d_i};
   end

   assign lvl_o  = pipe_q[STAGES-1];
   assign prev_o = pipe_q[STAGES];
endmodule

// File: rtl/cssp_timer.sv
`timescale 1ns/1ps
// Conversion duration counter.
module cssp_timer #(
   parameter int CYCLES = 400
) (
   input  logic clk,
   input  logic rst_n,
   input  logic en_i,
   output logic done_o
);
   localparam int TW = $clog2(CYCLES + 1);

   generate
      if (CYCLES < 2) begin : g_bad_cycles
         $error("cssp_timer: CYCLES must be at least 2");
      end
   endgenerate

   logic [TW-1:0] cnt_q;

   assign done_o = en_i && (cnt_q == TW'(CYCLES - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      cnt_q <= '0;
      else if (done_o) cnt_q <= '0;
      else if (en_i)   cnt_q <= cnt_q + 1'b1;
   end
endmodule

// File: rtl/cssp_shifter.sv
`timescale 1ns/1ps
// Holding shift register with bit-position counter.
module cssp_shifter #(
   parameter int WORD_W = 19,
   parameter int CNT_W  = $clog2(WORD_W)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load_i,
   input  logic [WORD_W-1:0] load_val_i,
   input  logic              shift_i,
   input  logic              clr_i,
   output logic              msb_o,
   output logic              last_o,
   output logic [CNT_W-1:0]  cnt_o,
   output logic [WORD_W-1:0] word_o
);
   generate
      if (WORD_W < 2) begin : g_bad_width
         $error("cssp_shifter: WORD_W must be at least 2");
      end
   endgenerate

   logic [WORD_W-1:0] word_q;
   logic [CNT_W-1:0]  cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         word_q <= '0;
         cnt_q  <= '0;
      end else if (load_i) begin
         word_q <= load_val_i;
         cnt_q  <= '0;
      end else if (clr_i) begin
         cnt_q  <= '0;
      end else if (shift_i) begin
         word_q <= {word_q[WORD_W-2:0], 1'b0};
         cnt_q  <= cnt_q + 1'b1;
      end
   end

   assign msb_o  = word_q[WORD_W-1];
   assign last_o = (cnt_q == CNT_W'(WORD_W - 1));
   assign cnt_o  = cnt_q;
   assign word_o = word_q;
endmodule

// File: rtl/conv_serial_port.sv
`timescale 1ns/1ps
module conv_serial_port
   import cssp_pkg::*;
#(
   parameter int MAG_W       = 16,
   parameter int CONV_CYCLES = 400,
   parameter int SYNC_STAGES = 2
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           csn_i,
   input  logic           sclk_i,
   input  logic [MAG_W:0] result_i,
   output logic           sdo_o,
   output logic           sdo_oe_o
);
   localparam int WORD_W = MAG_W + 3;
   localparam int CNT_W  = $clog2(WORD_W);

   generate
      if (MAG_W < 1) begin : g_bad_mag
         $error("conv_serial_port: MAG_W must be at least 1");
      end
   endgenerate

   logic cs_lvl, cs_prev, sk_lvl, sk_prev;
   logic cs_rise, sk_rise, sk_fall, sel;
   logic tmr_en, tmr_done;
   logic ld, sh, clr, word_msb, last_bit;
   logic [CNT_W-1:0]  bit_cnt;
   logic [WORD_W-1:0] word;
   cssp_state_e state_q, state_nx;

   cssp_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_cs_sync (
      .clk(clk), .rst_n(rst_n), .d_i(csn_i), .lvl_o(cs_lvl), .prev_o(cs_prev));

   cssp_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sk_sync (
      .clk(clk), .rst_n(rst_n), .d_i(sclk_i), .lvl_o(sk_lvl), .prev_o(sk_prev));

   assign sel     = ~cs_lvl;
   assign cs_rise = cs_lvl & ~cs_prev;
   assign sk_rise = sk_lvl & ~sk_prev;
   assign sk_fall = ~sk_lvl & sk_prev;

   cssp_timer #(.CYCLES(CONV_CYCLES)) u_timer (
      .clk(clk), .rst_n(rst_n), .en_i(tmr_en), .done_o(tmr_done));

   cssp_shifter #(.WORD_W(WORD_W), .CNT_W(CNT_W)) u_shifter (
      .clk(clk), .rst_n(rst_n), .load_i(ld),
      .load_val_i({2'b00, result_i}), .shift_i(sh), .clr_i(clr),
      .msb_o(word_msb), .last_o(last_bit), .cnt_o(bit_cnt), .word_o(word));

   always_comb begin
      state_nx = state_q;
      tmr_en   = 1'b0;
      ld       = 1'b0;
      sh       = 1'b0;
      clr      = 1'b0;
      unique case (state_q)
         ST_CONV: begin
            tmr_en = 1'b1;
            if (tmr_done) begin
               ld       = 1'b1;
               state_nx = ST_SLEEP;
            end
         end
         ST_SLEEP: begin
            if (sel && sk_rise) state_nx = ST_DATA;
         end
         ST_DATA: begin
            if (cs_rise) begin
               clr      = 1'b1;
               state_nx = ST_CONV;
            end else if (sel && sk_fall) begin
               if (last_bit) begin
                  clr      = 1'b1;
                  state_nx = ST_CONV;
               end else begin
                  sh = 1'b1;
               end
            end
         end
         default: state_nx = ST_CONV;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state_q <= ST_CONV;
      else        state_q <= state_nx;
   end

   assign sdo_oe_o = sel;
   assign sdo_o    = sel & ((state_q == ST_CONV) | word_msb);
endmodule

// File: rtl/cssp_checker.sv
`timescale 1ns/1ps
module cssp_checker
   import cssp_pkg::*;
#(
   parameter int WORD_W = 19,
   parameter int CNT_W  = 5
) (
   input logic              clk,
   input logic              rst_n,
   input cssp_state_e       state_q,
   input logic              sdo_o,
   input logic              sdo_oe_o,
   input logic              tmr_done,
   input logic              last_bit,
   input logic              sk_fall,
   input logic              cs_rise,
   input logic              sel,
   input logic [CNT_W-1:0]  bit_cnt,
   input logic [WORD_W-1:0] word
);
   p_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !sdo_oe_o |-> !sdo_o);

   p_busy_high_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_CONV && sdo_oe_o) |-> sdo_o);

   p_finish_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_CONV && tmr_done) |=> (state_q == ST_SLEEP));

   p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_SLEEP) |=> $stable(word));

   p_restart_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_DATA && sel && sk_fall && last_bit) |=> (state_q == ST_CONV));

   p_abort_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_DATA && cs_rise) |=> (state_q == ST_CONV));

   p_sleep_kept_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_SLEEP && cs_rise) |=> (state_q == ST_SLEEP));

   p_ignore_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_CONV) |-> (bit_cnt == '0));
endmodule

bind conv_serial_port cssp_checker #(.WORD_W(WORD_W), .CNT_W(CNT_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .state_q(state_q), .sdo_o(sdo_o),
   .sdo_oe_o(sdo_oe_o), .tmr_done(tmr_done), .last_bit(last_bit),
   .sk_fall(sk_fall), .cs_rise(cs_rise), .sel(sel), .bit_cnt(bit_cnt),
   .word(word));

// File: tb/conv_serial_port_bench.sv
`timescale 1ns/1ps
module conv_serial_port_bench;
   localparam int CONV = 60;
   localparam int H    = 6;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        csn_i = 1'b1;
   logic        sclk_i = 1'b0;
   logic [16:0] result_i = 17'h1_A5C3;
   logic        sdo_o, sdo_oe_o;

   int    n_checks = 0;
   int    n_fail = 0;
   string cur_req = "R1";
   bit    done_flag = 1'b0;

   always #2.5 clk = ~clk;

   conv_serial_port #(.MAG_W(16), .CONV_CYCLES(CONV), .SYNC_STAGES(2)) u_conv_serial_port (
      .clk(clk), .rst_n(rst_n), .csn_i(csn_i), .sclk_i(sclk_i),
      .result_i(result_i), .sdo_o(sdo_o), .sdo_oe_o(sdo_oe_o));

   task automatic chk(bit ok, string req, string what, int act, int exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   // Behavioural reference model: delayed copies of the raw inputs, a phase
   // number, a countdown and a bit list.
   bit cs_h[3];
   bit sk_h[3];
   int m_phase;   // 0 busy, 1 idle with result, 2 reading
   int m_left;
   int m_sent;
   bit m_bits[$];
   bit m_oe, m_sdo;

   always @(posedge clk) begin
      if (!rst_n) begin
         cs_h = '{1'b1, 1'b1, 1'b1};
         sk_h = '{1'b0, 1'b0, 1'b0};
         m_phase = 0; m_left = CONV; m_sent = 0;
         m_bits.delete();
         for (int i = 0; i < 19; i++) m_bits.push_back(1'b0);
      end else begin
         bit selm, csr, skr, skf;
         selm = !cs_h[1];
         csr  = cs_h[1] && !cs_h[2];
         skr  = sk_h[1] && !sk_h[2];
         skf  = !sk_h[1] && sk_h[2];
         if (m_phase == 0) begin
            m_left--;
            if (m_left == 0) begin
               m_bits.delete();
               m_bits.push_back(1'b0);
               m_bits.push_back(1'b0);
               for (int i = 16; i >= 0; i--) m_bits.push_back(result_i[i]);
               m_phase = 1;
            end
         end else if (m_phase == 1) begin
            if (selm && skr) m_phase = 2;
         end else begin
            if (csr) begin
               m_phase = 0; m_left = CONV; m_sent = 0;
            end else if (selm && skf) begin
               m_sent++;
               if (m_sent == 19) begin
                  m_phase = 0; m_left = CONV; m_sent = 0;
               end else begin
                  void'(m_bits.pop_front());
                  m_bits.push_back(1'b0);
               end
            end
         end
         cs_h[2] = cs_h[1]; cs_h[1] = cs_h[0]; cs_h[0] = csn_i;
         sk_h[2] = sk_h[1]; sk_h[1] = sk_h[0]; sk_h[0] = sclk_i;
      end
      m_oe  = !cs_h[1];
      m_sdo = m_oe && ((m_phase == 0) || m_bits[0]);
   end

   always @(negedge clk) begin
      if (rst_n && !done_flag) begin
         chk(sdo_o === m_sdo, cur_req, "model sdo_o", int'(sdo_o), int'(m_sdo));
         chk(sdo_oe_o === m_oe, cur_req, "model sdo_oe_o", int'(sdo_oe_o), int'(m_oe));
      end
   end

   task automatic cyc(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic pulse_sclk(int n);
      for (int i = 0; i < n; i++) begin
         sclk_i = 1'b1; cyc(H);
         sclk_i = 1'b0; cyc(H);
      end
   endtask

   task automatic read_bits(int nbits, output logic [18:0] got);
      got = '0;
      for (int i = 0; i < nbits; i++) begin
         got[18-i] = sdo_o;
         sclk_i = 1'b1; cyc(H);
         sclk_i = 1'b0; cyc(H);
      end
   endtask

   task automatic finish_run();
      done_flag = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
   endtask

   initial begin
      int wd;
      wd = 0;
      forever begin
         @(posedge clk);
         wd++;
         if (wd > 150000) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog expired actual=%0d expected=0", wd);
            finish_run();
         end
      end
   end

   initial begin
      logic [18:0] got;
      cyc(5);
      rst_n = 1'b1;
      cyc(2);
      cur_req = "R1";
      chk(sdo_oe_o == 1'b0 && sdo_o == 1'b0, "R1", "deselected after reset",
          {sdo_oe_o, sdo_o}, 0);

      // R10: output-enable two edges after chip select falls
      cur_req = "R10";
      csn_i = 1'b0;
      cyc(1);
      chk(sdo_oe_o == 1'b0, "R10", "oe after one edge", sdo_oe_o, 0);
      cyc(1);
      chk(sdo_oe_o == 1'b1, "R10", "oe after two edges", sdo_oe_o, 1);

      cur_req = "R2";
      chk(sdo_o == 1'b1, "R2", "busy flag during conversion", sdo_o, 1);

      // R9: serial clock toggled during conversion
      cur_req = "R9";
      pulse_sclk(3);
      chk(sdo_o == 1'b1, "R9", "still busy", sdo_o, 1);

      cur_req = "R3";
      cyc(CONV);
      chk(sdo_o == 1'b0 && sdo_oe_o, "R3", "idle flag after conversion", sdo_o, 0);

      // R5/R6: full read of result A
      cur_req = "R5";
      read_bits(19, got);
      chk(got == {2'b00, 17'h1_A5C3}, "R5", "word A", got, {2'b00, 17'h1_A5C3});
      cur_req = "R6";
      chk(sdo_o == 1'b1, "R6", "restart after 19th fall", sdo_o, 1);

      // R4: B captured, then input changed; chip select high through sleep
      cur_req = "R4";
      result_i = 17'h0_3C96;
      cyc(CONV);
      chk(sdo_o == 1'b0, "R3", "completion seen with select held low", sdo_o, 0);
      csn_i = 1'b1;
      cyc(H);
      result_i = 17'h1_0001;
      cur_req = "R11";
      pulse_sclk(4);
      chk(sdo_oe_o == 1'b0, "R11", "deselected", sdo_oe_o, 0);
      csn_i = 1'b0;
      cyc(H);
      read_bits(19, got);
      chk(got == {2'b00, 17'h0_3C96}, "R4", "held word B", got, {2'b00, 17'h0_3C96});

      // R7: abort after five bits
      cur_req = "R7";
      cyc(CONV);
      read_bits(5, got);
      chk(got[18:14] == {2'b00, 1'b1, 2'b00}, "R5", "first five bits of C",
          got[18:14], 5'b00100);
      csn_i = 1'b1;
      cyc(H);
      csn_i = 1'b0;
      cyc(H);
      chk(sdo_o == 1'b1, "R7", "conversion restarted on abort", sdo_o, 1);

      // R8: chip select pulse in sleep without clocks
      cur_req = "R8";
      cyc(CONV);
      csn_i = 1'b1;
      cyc(H);
      csn_i = 1'b0;
      cyc(H);
      chk(sdo_o == 1'b0, "R8", "still asleep", sdo_o, 0);
      read_bits(19, got);
      chk(got == {2'b00, 17'h1_0001}, "R8", "word C intact", got, {2'b00, 17'h1_0001});
      cyc(4);
      finish_run();
   end
endmodule